// File: doc/BRIEF.md
# Soft-Start Reference Staircase

This block produces the digital reference code that a converter's error amplifier follows while the supply comes up. Once the input-supply lockout has let go and a start pulse arrives, the code climbs from zero toward full scale, one count at a time, paced by the oscillator tick. It then holds at full scale. A separate completion flag rises after a fixed total number of ticks. An external DAC, which lies outside this block, turns the code into the reference voltage.

The same pulse also serves as the restart after a fault. When it arrives mid-ramp or after completion, the staircase repeats in full from zero. Reasserting lockout drops the code and the flag to zero at once. The ramp then stays parked until lockout is released and a fresh start pulse arrives. With the default parameters, the code rises by one count every 16 ticks and reaches 127 after 2032 ticks. The flag comes up on the 2047th tick.

Top module: `ss_ref_ramp`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, ref_code is 0 and ramp_done is 0.
- R2: When lockout is high at a clock edge, ref_code and ramp_done are 0 after that edge, whatever osc_tick and restart do in that cycle.
- R3: A ramp begins only when restart is high and lockout is low at a clock edge. With lockout low and no start pulse, ticks leave ref_code at 0.
- R4: After a start, ref_code equals floor(n/16), where n is the number of edges since the start at which osc_tick was high. Cycles without a tick change nothing, and each step is exactly +1.
- R5: ref_code saturates at 127 once 2032 ticks have been counted, and it never wraps or exceeds 127.
- R6: ramp_done rises at the edge that counts the 2047th tick, with ref_code at 127. It then stays high, and further ticks have no effect, until lockout or restart.
- R7: Lockout asserted mid-ramp or after completion clears both outputs. After release, ticks alone do not resume the ramp.
- R8: A restart with lockout low, mid-ramp or after completion, returns ref_code and ramp_done to 0 and restarts the count from zero. A tick in the same cycle as the restart is not counted.

Here ref_code is the 7-bit reference code and ramp_done is the completion flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| restart | input | 1 | Start or fault-restart pulse |
| lockout | input | 1 | Undervoltage lockout active (high) |
| ref_code | output | 7 | Reference code to the DAC |
| ramp_done | output | 1 | Ramp complete |

## Verification
The bench goes after the code saturation at 127 and the gap between tick 2032 and tick 2047. A design that wrapped the code would fall back to 0 there, and one that tied the flag to full scale would finish 15 ticks early. It spaces ticks out with idle cycles, so a divider that counted clocks instead of ticks runs visibly ahead. It also collides a restart with a tick in the same cycle, which catches a design that counts that tick into the new ramp. Lockout is asserted both mid-ramp and after completion, then released without a start pulse, which exposes a design that resumes or restarts by itself.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;

   // Number of bits needed to hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned bits_for(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

   // True when n is a power of two.
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/ss_step_divider.sv
// Divides qualified oscillator ticks into code-step strobes.
module ss_step_divider #(
   parameter int unsigned TICKS_PER_STEP = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick_en,
   output logic step
);
   import ss_ramp_pkg::*;

   localparam int unsigned SUB_W = bits_for(TICKS_PER_STEP);

   logic [SUB_W-1:0] sub_q;

   generate
      if (is_pow2(TICKS_PER_STEP)) begin : g_wrap
         // Power-of-two divide: the counter wraps by itself.
         assign step = tick_en && (&sub_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sub_q <= '0;
            else if (clr)     sub_q <= '0;
            else if (tick_en) sub_q <= sub_q + 1'b1;
         end
      end else begin : g_cmp
         // Arbitrary divide: compare against the terminal count.
         assign step = tick_en && (sub_q == SUB_W'(TICKS_PER_STEP - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sub_q <= '0;
            else if (clr)     sub_q <= '0;
            else if (step)    sub_q <= '0;
            else if (tick_en) sub_q <= sub_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/ss_span_counter.sv
// Counts the total ramp length in ticks and owns the run / done state.
module ss_span_counter #(
   parameter int unsigned RAMP_CYCLES = 2047
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lockout,
   input  logic start,
   input  logic tick_en,
   output logic running,
   output logic done
);
   import ss_ramp_pkg::*;

   localparam int unsigned CNT_W = bits_for(RAMP_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             done_q;
   logic             last;

   assign last = tick_en && (cnt_q == CNT_W'(RAMP_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (lockout) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= '0;
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (tick_en) begin
         cnt_q <= cnt_q + 1'b1;
         if (last) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign running = run_q;
   assign done    = done_q;

endmodule

// File: rtl/ss_code_accum.sv
// Saturating up-counter that holds the reference code.
module ss_code_accum #(
   parameter int unsigned CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [CODE_W-1:0] code
);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          code_q <= '0;
      else if (clr)                        code_q <= '0;
      else if (step && code_q != CODE_MAX) code_q <= code_q + 1'b1;
   end

   assign code = code_q;

endmodule

// File: rtl/ss_ref_ramp.sv
// Soft-start reference staircase: top level.
module ss_ref_ramp #(
   parameter int unsigned CODE_W         = 7,
   parameter int unsigned TICKS_PER_STEP = 16,
   parameter int unsigned RAMP_CYCLES    = 2047
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              restart,
   input  logic              lockout,
   output logic [CODE_W-1:0] ref_code,
   output logic              ramp_done
);
   localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code_w
         $error("ss_ref_ramp: CODE_W out of range");
      end
      if (TICKS_PER_STEP < 2) begin : g_bad_tps
         $error("ss_ref_ramp: TICKS_PER_STEP must be at least 2");
      end
      if (RAMP_CYCLES < CODE_MAX * TICKS_PER_STEP) begin : g_bad_span
         $error("ss_ref_ramp: RAMP_CYCLES shorter than the staircase");
      end
   endgenerate

   logic start;
   logic clr;
   logic running;
   logic tick_en;
   logic step;

   // Lockout outranks restart, and restart outranks a tick in the same cycle.
   assign start   = restart && !lockout;
   assign clr     = lockout || restart;
   assign tick_en = osc_tick && running && !clr;

   ss_step_divider #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .tick_en (tick_en),
      .step    (step)
   );

   ss_span_counter #(.RAMP_CYCLES(RAMP_CYCLES)) u_span (
      .clk     (clk),
      .rst_n   (rst_n),
      .lockout (lockout),
      .start   (start),
      .tick_en (tick_en),
      .running (running),
      .done    (ramp_done)
   );

   ss_code_accum #(.CODE_W(CODE_W)) u_code (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (step),
      .code  (ref_code)
   );

endmodule

// File: rtl/ss_ref_ramp_chk.sv
module ss_ref_ramp_chk #(
   parameter int unsigned CODE_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              osc_tick,
   input logic              restart,
   input logic              lockout,
   input logic [CODE_W-1:0] ref_code,
   input logic              ramp_done
);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   AST_LOCKOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |=> (ref_code == '0 && !ramp_done)); // R2

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !lockout) |=> (ref_code == '0 && !ramp_done)); // R8

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_tick && !restart && !lockout) |=> ($stable(ref_code) && $stable(ramp_done))); // R4

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !lockout) |=>
         ({1'b0, ref_code} == {1'b0, $past(ref_code)} ||
          {1'b0, ref_code} == {1'b0, $past(ref_code)} + 1'b1)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_code == CODE_MAX && !restart && !lockout) |=> ref_code == CODE_MAX); // R5

   AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_done |-> ref_code == CODE_MAX); // R6

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_done && !restart && !lockout) |=> ramp_done); // R6

endmodule

bind ss_ref_ramp ss_ref_ramp_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .osc_tick  (osc_tick),
   .restart   (restart),
   .lockout   (lockout),
   .ref_code  (ref_code),
   .ramp_done (ramp_done)
);

// File: tb/ss_ref_ramp_tb_top.sv
`timescale 1ns/1ps
module ss_ref_ramp_tb_top;

   typedef struct {
      int    code;
      bit    done;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       restart = 1'b0;
   logic       lockout = 1'b0;
   logic [6:0] ref_code;
   logic       ramp_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   exp_t sb_q[$];

   // Reference model state, built from the requirements.
   int m_code = 0, m_sub = 0, m_cnt = 0;
   bit m_done = 0, m_run = 0;

   always #10 clk = ~clk;

   ss_ref_ramp dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_tick  (osc_tick),
      .restart   (restart),
      .lockout   (lockout),
      .ref_code  (ref_code),
      .ramp_done (ramp_done)
   );

   task automatic drive(input bit tk, input bit rs, input bit lo, input string tag);
      exp_t e;
      @(negedge clk);
      osc_tick = tk;
      restart  = rs;
      lockout  = lo;
      if (lo) begin
         m_code = 0; m_sub = 0; m_cnt = 0; m_done = 0; m_run = 0;
      end else if (rs) begin
         m_code = 0; m_sub = 0; m_cnt = 0; m_done = 0; m_run = 1;
      end else if (tk && m_run) begin
         m_sub++;
         if (m_sub == 16) begin
            m_sub = 0;
            if (m_code < 127) m_code++;
         end
         m_cnt++;
         if (m_cnt == 2047) begin
            m_done = 1;
            m_run  = 0;
         end
      end
      e.code = m_code;
      e.done = m_done;
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   task automatic ticks(input int n, input int gap, input string tag);
      for (int i = 0; i < n; i++) begin
         drive(1'b1, 1'b0, 1'b0, tag);
         for (int g = 0; g < gap; g++) drive(1'b0, 1'b0, 1'b0, tag);
      end
   endtask

   // Monitor: compare outputs a quarter period after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (int'(ref_code) != e.code || ramp_done != e.done) begin
               n_fail++;
               $display("FAIL %s: code=%0d done=%0b expected code=%0d done=%0b at %0t",
                        e.tag, ref_code, ramp_done, e.code, e.done, $time);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #5;
      n_checks++;
      if (ref_code != 0 || ramp_done != 0) begin
         n_fail++;
         $display("FAIL R1: code=%0d done=%0b expected code=0 done=0", ref_code, ramp_done);
      end
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 1'b0, "R1");

      // R2: lockout held, ticks and restarts ignored
      for (int i = 0; i < 40; i++) drive(1'b1, (i % 5) == 0, 1'b1, "R2");

      // R3: lockout released, ticks but no start pulse
      ticks(40, 0, "R3");

      // R3/R4: start, ticks every cycle
      drive(1'b0, 1'b1, 1'b0, "R3");
      ticks(1000, 0, "R4");
      // R5: through saturation
      ticks(1040, 0, "R5");
      // R6: up to and past completion
      ticks(40, 0, "R6");
      for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, 1'b0, "R6");

      // R8: restart after completion, coinciding with a tick
      drive(1'b1, 1'b1, 1'b0, "R8");
      // R4: sparse ticks
      ticks(200, 2, "R4");
      // R8: restart mid-ramp with tick
      drive(1'b1, 1'b1, 1'b0, "R8");
      ticks(100, 1, "R8");

      // R7: lockout mid-ramp, release, ticks alone do nothing
      drive(1'b1, 1'b0, 1'b1, "R7");
      drive(1'b1, 1'b0, 1'b1, "R7");
      ticks(50, 0, "R7");

      // Full ramp, then lockout after completion
      drive(1'b0, 1'b1, 1'b0, "R3");
      ticks(2060, 0, "R6");
      drive(1'b0, 1'b0, 1'b1, "R7");
      ticks(30, 0, "R7");

      repeat (3) @(posedge clk);
      #7;
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule